// File: doc/BRIEF.md
# MSI Vector Capture Controller

This block sits on the inbound write path of a root port. Message writes arrive on a simple strobe interface that carries a 64-bit address and a 32-bit data word. When a write's address equals the programmed 64-bit message target, the data word is taken as a vector number. If that vector is enabled, a pending bit is latched for it. Vectors are organised in groups of 32. Vector `v` lands in group `v/32` at bit `v mod 32`.

Software programs the target address and each group's enable, mask and status words over a 32-bit register port. Reads on that port are combinational from the register address. A pending bit is removed by writing a one to it. A single level-sensitive interrupt output is high while any group has a pending bit that is not masked. A pending bit appears in the status word, and in the interrupt output, right after the clock edge that samples the message.

Top module: `msi_vector_capture`

## Requirements
- R1: After reset every register (target words, enable, mask and status of all groups) reads zero and `irq_out` is low.
- R2: The target low word is at register offset 0x820 and the high word at 0x824. Both read back what was last written.
- R3: Group g's enable word is at offset 0x828 + 12*g, its mask word at 0x82C + 12*g and its status word at 0x830 + 12*g, for g = 0..7. Enable and mask read back what was last written.
- R4: A message write whose 64-bit address equals {high word, low word} and whose data d is below 256 sets status bit d mod 32 of group d/32 at the next clock edge, provided that bit is enabled.
- R5: A matching message for a vector whose enable bit is 0 leaves that status bit unchanged.
- R6: A message write whose address differs from the target in either word changes no status bit.
- R7: A matching message whose data is 256 or above changes no status bit. This includes values whose low 8 bits name an enabled vector.
- R8: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged. A status write never sets a bit.
- R9: A masked status bit is still recorded and reads back as 1, but does not drive `irq_out`.
- R10: `irq_out` is high exactly when some group has a status bit that is 1 and whose mask bit is 0.
- R11: When a message sets a bit and a status write clears the same bit in the same cycle, the bit ends up set. Other bits cleared by that write still clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_wr | input | 1 | Inbound message write strobe, one cycle per write |
| msg_addr | input | 64 | Address of the inbound write |
| msg_data | input | 32 | Data of the inbound write (vector number) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`; zero for unmapped offsets |
| irq_out | output | 1 | Level interrupt: any unmasked pending vector |

## Verification
Two functions can meet on one bit in the same cycle: an arriving message that sets a pending bit, and a software write-one-to-clear of that same bit. The bench drives the message strobe and a status-word register write in the same clock cycle. In one case both target the same vector. In the other, the write clears a neighbouring bit while the message sets the next bit. The bench then reads the status word and checks that the hit bit is still set and that the neighbour has cleared.

// File: rtl/msivc_pkg.sv
package msivc_pkg;

    // Register port geometry
    localparam int REG_AW      = 12;
    localparam int REG_DW      = 32;
    localparam int VEC_PER_GRP = 32;

    // Offsets software depends on
    localparam int TGT_LO_OFF  = 'h820;
    localparam int TGT_HI_OFF  = 'h824;
    localparam int GRP_BASE    = 'h828;
    localparam int GRP_STRIDE  = 12;
    localparam int EN_REL      = 0;
    localparam int MASK_REL    = 4;
    localparam int STAT_REL    = 8;

    typedef struct packed {
        logic [REG_DW-1:0] lo;
        logic [REG_DW-1:0] hi;
    } target_t;

    typedef struct packed {
        logic [VEC_PER_GRP-1:0] en;
        logic [VEC_PER_GRP-1:0] mask;
        logic [VEC_PER_GRP-1:0] status;
    } grp_state_t;

    function automatic logic [REG_AW-1:0] grp_off(input int g, input int rel);
        return REG_AW'(GRP_BASE + g * GRP_STRIDE + rel);
    endfunction

endpackage

// File: rtl/msivc_msg_decode.sv
module msivc_msg_decode
    import msivc_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    localparam int NUM_VEC   = NUM_GROUPS * VEC_PER_GRP,
    localparam int VEC_W     = $clog2(NUM_VEC)
) (
    input  logic               msg_wr,
    input  logic [63:0]        msg_addr,
    input  logic [31:0]        msg_data,
    input  logic [63:0]        target,
    output logic [NUM_VEC-1:0] hit_vec
);

    logic addr_match;
    logic data_in_range;

    always_comb begin
        addr_match    = (msg_addr == target);
        data_in_range = (msg_data[31:VEC_W] == '0);
        hit_vec       = '0;
        if (msg_wr && addr_match && data_in_range) begin
            hit_vec = NUM_VEC'(1) << msg_data[VEC_W-1:0];
        end
    end

endmodule

// File: rtl/msivc_group.sv
module msivc_group
    import msivc_pkg::*;
#(
    parameter int GIDX = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [REG_DW-1:0]      reg_wdata,
    input  logic [VEC_PER_GRP-1:0] set_vec,
    output logic [VEC_PER_GRP-1:0] en_o,
    output logic [VEC_PER_GRP-1:0] mask_o,
    output logic [VEC_PER_GRP-1:0] status_o,
    output logic [REG_DW-1:0]      rd_data,
    output logic                   pend_o
);

    localparam logic [REG_AW-1:0] EN_A   = grp_off(GIDX, EN_REL);
    localparam logic [REG_AW-1:0] MASK_A = grp_off(GIDX, MASK_REL);
    localparam logic [REG_AW-1:0] STAT_A = grp_off(GIDX, STAT_REL);

    grp_state_t st_d, st_q;
    logic [VEC_PER_GRP-1:0] clr_vec;

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (reg_wr && reg_addr == EN_A)   st_d.en   = reg_wdata;
        if (reg_wr && reg_addr == MASK_A) st_d.mask = reg_wdata;
        if (reg_wr && reg_addr == STAT_A) clr_vec   = reg_wdata;
        // clear first, then a same-cycle enabled set wins
        st_d.status = (st_q.status & ~clr_vec) | (set_vec & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            EN_A:    rd_data = st_q.en;
            MASK_A:  rd_data = st_q.mask;
            STAT_A:  rd_data = st_q.status;
            default: rd_data = '0;
        endcase
    end

    assign en_o     = st_q.en;
    assign mask_o   = st_q.mask;
    assign status_o = st_q.status;
    assign pend_o   = |(st_q.status & ~st_q.mask);

endmodule

// File: rtl/msi_vector_capture.sv
module msi_vector_capture
    import msivc_pkg::*;
#(
    parameter int NUM_GROUPS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_wr,
    input  logic [63:0]       msg_addr,
    input  logic [31:0]       msg_data,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq_out
);

    localparam int NUM_VEC = NUM_GROUPS * VEC_PER_GRP;

    target_t tgt_d, tgt_q;
    logic [63:0]         target_addr;
    logic [NUM_VEC-1:0]  hit_vec;
    logic [NUM_VEC-1:0]  enable_all;
    logic [NUM_VEC-1:0]  mask_all;
    logic [NUM_VEC-1:0]  status_all;
    logic [NUM_GROUPS-1:0] grp_pend;
    logic [REG_DW-1:0]   grp_rd [NUM_GROUPS];

    // Target address registers
    always_comb begin
        tgt_d = tgt_q;
        if (reg_wr && reg_addr == REG_AW'(TGT_LO_OFF)) tgt_d.lo = reg_wdata;
        if (reg_wr && reg_addr == REG_AW'(TGT_HI_OFF)) tgt_d.hi = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tgt_q <= '0;
        else        tgt_q <= tgt_d;
    end

    assign target_addr = {tgt_q.hi, tgt_q.lo};

    msivc_msg_decode #(.NUM_GROUPS(NUM_GROUPS)) i_decode (
        .msg_wr   (msg_wr),
        .msg_addr (msg_addr),
        .msg_data (msg_data),
        .target   (target_addr),
        .hit_vec  (hit_vec)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        msivc_group #(.GIDX(g)) i_group (
            .clk      (clk),
            .rst_n    (rst_n),
            .reg_wr   (reg_wr),
            .reg_addr (reg_addr),
            .reg_wdata(reg_wdata),
            .set_vec  (hit_vec[g*VEC_PER_GRP +: VEC_PER_GRP]),
            .en_o     (enable_all[g*VEC_PER_GRP +: VEC_PER_GRP]),
            .mask_o   (mask_all[g*VEC_PER_GRP +: VEC_PER_GRP]),
            .status_o (status_all[g*VEC_PER_GRP +: VEC_PER_GRP]),
            .rd_data  (grp_rd[g]),
            .pend_o   (grp_pend[g])
        );
    end

    // Read mux: at most one source decodes a given offset
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(TGT_LO_OFF)) reg_rdata = tgt_q.lo;
        if (reg_addr == REG_AW'(TGT_HI_OFF)) reg_rdata = tgt_q.hi;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            reg_rdata = reg_rdata | grp_rd[g];
        end
    end

    assign irq_out = |grp_pend;

endmodule

// File: rtl/msivc_chk.sv
module msivc_chk
    import msivc_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    localparam int NUM_VEC   = NUM_GROUPS * VEC_PER_GRP,
    localparam int VEC_W     = $clog2(NUM_VEC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_wr,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic               reg_wr,
    input logic               irq_out,
    input logic [63:0]        target_addr,
    input logic [NUM_VEC-1:0] enable_all,
    input logic [NUM_VEC-1:0] mask_all,
    input logic [NUM_VEC-1:0] status_all
);

    logic [VEC_W-1:0] idx;
    logic             good_msg;

    assign idx      = msg_data[VEC_W-1:0];
    assign good_msg = msg_wr && (msg_addr == target_addr) && (msg_data[31:VEC_W] == '0);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (status_all == '0 && !irq_out));

    // R4 R11
    enabled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_msg && enable_all[idx]) |=> status_all[$past(idx)]);

    // R5
    disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_wr && !enable_all[idx] && !status_all[idx]) |=> !status_all[$past(idx)]);

    // R6 R7
    ignored_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !good_msg) |=> (status_all == $past(status_all)));

    // R8
    only_w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((status_all & $past(status_all)) == $past(status_all)));

    // R9 R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_all & ~mask_all) == '0) |-> !irq_out);

endmodule

bind msi_vector_capture msivc_chk #(.NUM_GROUPS(NUM_GROUPS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_wr     (msg_wr),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data),
    .reg_wr     (reg_wr),
    .irq_out    (irq_out),
    .target_addr(target_addr),
    .enable_all (enable_all),
    .mask_all   (mask_all),
    .status_all (status_all)
);

// File: tb/test_msi_vector_capture.sv
`timescale 1ns/100ps
module test_msi_vector_capture;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_wr = 1'b0;
    logic [63:0] msg_addr = '0;
    logic [31:0] msg_data = '0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    always #2.5 clk = ~clk;

    msi_vector_capture i_msi_vector_capture (
        .clk(clk), .rst_n(rst_n),
        .msg_wr(msg_wr), .msg_addr(msg_addr), .msg_data(msg_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference model built from the requirements
    logic [31:0] m_en [8];
    logic [31:0] m_mk [8];
    logic [31:0] m_st [8];
    logic [31:0] m_lo, m_hi;

    localparam logic [63:0] TGT = 64'h0000_0000_FEE0_1000;

    function automatic logic [11:0] en_a(int g);   return 12'(12'h828 + 12*g); endfunction
    function automatic logic [11:0] mk_a(int g);   return 12'(12'h82C + 12*g); endfunction
    function automatic logic [11:0] st_a(int g);   return 12'(12'h830 + 12*g); endfunction

    function automatic logic [31:0] model_read(logic [11:0] a);
        if (a == 12'h820) return m_lo;
        if (a == 12'h824) return m_hi;
        for (int g = 0; g < 8; g++) begin
            if (a == en_a(g)) return m_en[g];
            if (a == mk_a(g)) return m_mk[g];
            if (a == st_a(g)) return m_st[g];
        end
        return 32'h0;
    endfunction

    function automatic void model_write(logic [11:0] a, logic [31:0] d);
        if (a == 12'h820) m_lo = d;
        if (a == 12'h824) m_hi = d;
        for (int g = 0; g < 8; g++) begin
            if (a == en_a(g)) m_en[g] = d;
            if (a == mk_a(g)) m_mk[g] = d;
            if (a == st_a(g)) m_st[g] = m_st[g] & ~d;
        end
    endfunction

    function automatic void model_msg(logic [63:0] a, logic [31:0] d);
        if (a == {m_hi, m_lo} && d < 256 && m_en[d/32][d%32])
            m_st[d/32][d%32] = 1'b1;
    endfunction

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int g = 0; g < 8; g++) r |= |(m_st[g] & ~m_mk[g]);
        return r;
    endfunction

    // Driver tasks: all start and end at posedge + 1
    task automatic reg_write(logic [11:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic send_msg(logic [63:0] a, logic [31:0] d);
        msg_wr = 1'b1; msg_addr = a; msg_data = d;
        @(posedge clk); #1;
        msg_wr = 1'b0;
        model_msg(a, d);
    endtask

    task automatic msg_and_write(logic [63:0] ma, logic [31:0] md,
                                 logic [11:0] ra, logic [31:0] rd);
        msg_wr = 1'b1; msg_addr = ma; msg_data = md;
        reg_wr = 1'b1; reg_addr = ra; reg_wdata = rd;
        @(posedge clk); #1;
        msg_wr = 1'b0; reg_wr = 1'b0;
        model_write(ra, rd);
        model_msg(ma, md);
    endtask

    task automatic expect_reg(logic [11:0] a, string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = model_read(a); it.tag = tag;
        reg_addr = a;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic expect_irq(string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, model_irq()}; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    // Monitor: compares at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = q.pop_front();
            got = it.is_irq ? {31'b0, irq_out} : reg_rdata;
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s: got=%h expected=%h", it.tag, got, it.exp);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 8; g++) begin m_en[g] = 0; m_mk[g] = 0; m_st[g] = 0; end
        m_lo = 0; m_hi = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_reg(12'h820, "R1 target lo");
        expect_reg(12'h824, "R1 target hi");
        expect_reg(en_a(0), "R1 enable g0");
        expect_reg(st_a(0), "R1 status g0");
        expect_reg(st_a(7), "R1 status g7");
        expect_irq("R1 irq");

        // R2 target address
        reg_write(12'h824, 32'h0000_0005);
        expect_reg(12'h824, "R2 hi readback");
        reg_write(12'h824, 32'h0);
        reg_write(12'h820, TGT[31:0]);
        expect_reg(12'h820, "R2 lo readback");

        // R3 group triplets
        for (int g = 0; g < 8; g++)
            reg_write(en_a(g), (g == 3) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF);
        reg_write(mk_a(5), 32'h1234_5678);
        for (int g = 0; g < 8; g++) expect_reg(en_a(g), "R3 enable readback");
        expect_reg(mk_a(5), "R3 mask readback");
        reg_write(mk_a(5), 32'h0);

        // R4 enabled vectors
        send_msg(TGT, 32'd5);
        expect_reg(st_a(0), "R4 vector 5");
        expect_irq("R4 R10 irq after vector 5");
        send_msg(TGT, 32'd255);
        expect_reg(st_a(7), "R4 vector 255");
        send_msg(TGT, 32'd32);
        expect_reg(st_a(1), "R4 vector 32");

        // R5 disabled vector
        send_msg(TGT, 32'd96);
        expect_reg(st_a(3), "R5 disabled vector 96");

        // R6 address mismatch (low word, then high word)
        send_msg(TGT ^ 64'h4, 32'd40);
        expect_reg(st_a(1), "R6 low word mismatch");
        send_msg(TGT | 64'h1_0000_0000, 32'd41);
        expect_reg(st_a(1), "R6 high word mismatch");

        // R8 write-one-to-clear
        reg_write(st_a(0), 32'h0);
        expect_reg(st_a(0), "R8 zero write keeps");
        reg_write(st_a(0), 32'h20);
        expect_reg(st_a(0), "R8 one clears");
        reg_write(st_a(1), 32'hFFFF_FFFF);
        expect_reg(st_a(1), "R8 clear all ones");
        reg_write(st_a(2), 32'h0000_00FF);
        expect_reg(st_a(2), "R8 write never sets");

        // R7 out-of-range data aliasing to vector 5
        send_msg(TGT, 32'd261);
        expect_reg(st_a(0), "R7 data 261");
        send_msg(TGT, 32'd256);
        expect_reg(st_a(0), "R7 data 256");

        // R9 / R10 masking
        reg_write(mk_a(7), 32'h8000_0000);
        expect_reg(st_a(7), "R9 masked bit still pending");
        expect_irq("R9 masked irq low");
        send_msg(TGT, 32'd200);
        expect_irq("R10 unmasked g6 raises irq");
        reg_write(st_a(6), 32'h0000_0100);
        expect_irq("R10 irq drops after clear");
        reg_write(mk_a(7), 32'h0);
        expect_irq("R10 unmask raises irq");
        reg_write(st_a(7), 32'h8000_0000);
        expect_irq("R10 irq low when empty");

        // R11 set and clear collide
        send_msg(TGT, 32'd70);
        msg_and_write(TGT, 32'd70, st_a(2), 32'h0000_0040);
        expect_reg(st_a(2), "R11 same bit set wins");
        msg_and_write(TGT, 32'd71, st_a(2), 32'h0000_0040);
        expect_reg(st_a(2), "R11 neighbour clears, new bit sets");

        while (q.size() > 0) @(posedge clk);
        @(posedge clk); #1;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule